// File: doc/BRIEF.md
# Window Watchdog with Initial Timeout

This block supervises a host processor through a single trigger pin. Once armed, it grants a long initial timeout. Within that timeout the first good trigger is accepted at any moment. That trigger opens a repeating window.

Each window is split into two parts:
- **Closed part:** the first quarter of the window. A trigger here is too early and counts as a fault.
- **Open part:** the remaining three quarters. A trigger here is accepted and restarts the window from its closed part.

A fault raises a single-cycle failure pulse and re-arms the initial timeout. There are two fault cases: a trigger in the closed part, and no trigger before the window ends. The same happens when the initial timeout expires with no trigger.

The initial timeout is also re-armed, without a failure, in two other cases:
- the surrounding mode logic signals entry into a supervised mode;
- the reset-release signal rises while the chip is in its active mode.

The trigger pin is asynchronous. It passes through a synchronizer and a stability filter, so short glitches never reach the window logic. A select input chooses between two window lengths: a nominal one and a slightly longer one, used when the system clock is frequency-spread. All times are counted in clock cycles and set by parameters. The defaults are small, so the block is easy to exercise in simulation. A real build scales them to about 300 ms for the initial timeout, 20 ms or 22 ms for the window, and about 1.2 µs for the filter.

Top module: `wwd_window_watchdog`

## Requirements
- R1: A trigger pulse held high for fewer than FILT_LEN consecutive clock edges has no effect. A pulse held for FILT_LEN or more edges gives exactly one trigger event, taken by the window logic SYNC_STAGES+FILT_LEN edges after the first edge that samples it high. The defaults are FILT_LEN=4 and SYNC_STAGES=2, so the event is taken 6 edges later.
- R2: After reset or a re-arm, if no trigger event occurs, `wd_fail` goes high after the INIT_CYC-th clock edge. The initial timeout then starts again and repeats.
- R3: During the initial timeout, a trigger event gives no failure and starts a window at its closed part.
- R4: In a window, a trigger event taken at the k-th edge after the window start, with k <= WIN/4, is early. It produces a `wd_fail` pulse on that edge and re-arms the initial timeout.
- R5: In a window, a trigger event with WIN/4 < k <= WIN gives no failure and restarts the window.
- R6: If a window reaches its WIN-th edge with no trigger event, `wd_fail` pulses on that edge and the initial timeout is re-armed.
- R7: WIN is WIN_CYC (default 80) when `ss_sel`=0 and WIN_SS_CYC (default 88) when `ss_sel`=1. The closed part scales with it.
- R8: A one-cycle `mode_enter` pulse re-arms the initial timeout in any state and produces no failure.
- R9: A rising edge of `release_lvl` re-arms the initial timeout only while `active_mode`=1. Holding `release_lvl` high does not re-arm again. With `active_mode`=0 the edge has no effect.
- R10: `wd_fail` is low during reset and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| trig_in | input | 1 | Raw trigger from the supervised processor (asynchronous) |
| mode_enter | input | 1 | One-cycle pulse on entry into a supervised mode |
| active_mode | input | 1 | High while the chip is in its active mode |
| release_lvl | input | 1 | Reset-release level; its rising edge re-arms in active mode |
| ss_sel | input | 1 | Selects the longer window length |
| wd_fail | output | 1 | One-cycle watchdog failure pulse |

## Verification
The hardest situation to reach from the pins is a trigger event landing on a chosen window edge: the last closed edge, the first open edge, or the final edge of the window. The trigger is seen only through the synchronizer and filter delay. The stimulus therefore counts back SYNC_STAGES+FILT_LEN edges from the target position before it raises the pin. It also spaces pulses far enough apart that the filter can fall again before the next rise. The short-pulse case, and re-arms whose effect shows only at a later timeout, are judged by when the next failure pulse appears.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  // Supervision phase of the window engine
  typedef enum logic [0:0] {
    WWD_ARMING = 1'b0,   // long initial timeout running
    WWD_WINDOW = 1'b1    // repeating closed/open window running
  } wwd_state_e;

  function automatic int wwd_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wwd_trig_filter.sv
// Synchronizes the raw trigger, rejects pulses shorter than FILT_LEN
// samples and emits a one-cycle event on each qualified rising edge.
module wwd_trig_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic trig_o
);

  localparam int FW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp;
  logic [FW-1:0]          cnt_q, cnt_d;
  logic                   filt_q, filt_d;
  logic                   prev_q;
  logic                   cnt_en;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= raw_i;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      end
    end
  endgenerate

  assign samp = sync_q[SYNC_STAGES-1];

  // Stability counter: output follows only after FILT_LEN equal samples
  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (samp != filt_q) begin
      if (cnt_q == FW'(FILT_LEN - 1)) begin
        filt_d = samp;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + FW'(1);
      end
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      filt_q <= filt_d;
      prev_q <= filt_q;
    end
  end

  assign trig_o = filt_q & ~prev_q;

  // A qualified edge lasts one cycle only
  assert_trig_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // The filtered level only ever moves toward the synchronized input
  assert_filt_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(samp) == filt_q));

endmodule

// File: rtl/wwd_rearm_detect.sv
// Combines the mode-entry pulse and the active-mode reset-release rise
// into a single re-arm request for the window engine.
module wwd_rearm_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_enter_i,
  input  logic active_i,
  input  logic release_i,
  output logic rearm_o
);

  logic rel_q;
  logic rel_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= release_i;
  end

  assign rel_rise = release_i & ~rel_q;
  assign rearm_o  = mode_enter_i | (active_i & rel_rise);

  // A held release level must not keep re-arming
  assert_release_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_o && !mode_enter_i) |=> (!rearm_o || mode_enter_i || !release_i));

endmodule

// File: rtl/wwd_window_fsm.sv
// Initial timeout plus repeating closed/open window, failure pulse out.
module wwd_window_fsm
  import wwd_pkg::*;
#(
  parameter int INIT_CYC   = 200,
  parameter int WIN_CYC    = 80,
  parameter int WIN_SS_CYC = 88,
  parameter int CW         = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic rearm_i,
  input  logic ss_sel_i,
  output logic fail_o
);

  localparam int CLOSED_N = WIN_CYC / 4;
  localparam int CLOSED_S = WIN_SS_CYC / 4;
  localparam int WIN_MAX  = (WIN_CYC > WIN_SS_CYC) ? WIN_CYC : WIN_SS_CYC;

  wwd_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fail_q, fail_d;
  logic [CW-1:0] closed_len;
  logic [CW-1:0] win_last;

  always_comb begin
    closed_len = ss_sel_i ? CW'(CLOSED_S)       : CW'(CLOSED_N);
    win_last   = ss_sel_i ? CW'(WIN_SS_CYC - 1) : CW'(WIN_CYC - 1);
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CW'(1);
    fail_d  = 1'b0;
    if (rearm_i) begin
      state_d = WWD_ARMING;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        WWD_ARMING: begin
          if (trig_i) begin
            state_d = WWD_WINDOW;
            cnt_d   = '0;
          end else if (cnt_q >= CW'(INIT_CYC - 1)) begin
            fail_d  = 1'b1;
            cnt_d   = '0;
          end
        end
        WWD_WINDOW: begin
          if (trig_i) begin
            cnt_d = '0;
            if (cnt_q < closed_len) begin
              fail_d  = 1'b1;
              state_d = WWD_ARMING;
            end
          end else if (cnt_q >= win_last) begin
            fail_d  = 1'b1;
            state_d = WWD_ARMING;
            cnt_d   = '0;
          end
        end
        default: begin
          state_d = WWD_ARMING;
          cnt_d   = '0;
        end
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WWD_ARMING;
      cnt_q   <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fail_q  <= fail_d;
    end
  end

  assign fail_o = fail_q;

  assert_rearm_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> (!fail_o && state_q == WWD_ARMING && cnt_q == '0));

  assert_fail_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o);

  assert_fail_rearms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (state_q == WWD_ARMING && cnt_q == '0));

  assert_early_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WWD_WINDOW && trig_i && !rearm_i && cnt_q < closed_len) |=> fail_o);

  assert_open_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WWD_WINDOW && trig_i && !rearm_i && cnt_q >= closed_len)
      |=> (!fail_o && state_q == WWD_WINDOW && cnt_q == '0));

  assert_win_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WWD_WINDOW) |-> (cnt_q < CW'(WIN_MAX)));

endmodule

// File: rtl/wwd_window_watchdog.sv
// Window watchdog top: trigger filter, re-arm detection, window engine.
module wwd_window_watchdog
  import wwd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int INIT_CYC    = 200,
  parameter int WIN_CYC     = 80,
  parameter int WIN_SS_CYC  = 88
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic mode_enter,
  input  logic active_mode,
  input  logic release_lvl,
  input  logic ss_sel,
  output logic wd_fail
);

  localparam int CNT_MAX = wwd_max3(INIT_CYC, WIN_CYC, WIN_SS_CYC);
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic trig_evt;
  logic rearm;

  wwd_trig_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_LEN    (FILT_LEN)
  ) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (trig_in),
    .trig_o (trig_evt)
  );

  wwd_rearm_detect u_rearm (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_enter_i (mode_enter),
    .active_i     (active_mode),
    .release_i    (release_lvl),
    .rearm_o      (rearm)
  );

  wwd_window_fsm #(
    .INIT_CYC   (INIT_CYC),
    .WIN_CYC    (WIN_CYC),
    .WIN_SS_CYC (WIN_SS_CYC),
    .CW         (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig_evt),
    .rearm_i  (rearm),
    .ss_sel_i (ss_sel),
    .fail_o   (wd_fail)
  );

endmodule

// File: tb/wwd_window_watchdog_tb.sv
module wwd_window_watchdog_tb;

  localparam int CLK_PERIOD = 10;
  localparam int F      = 4;
  localparam int SYNC   = 2;
  localparam int LAT    = SYNC + F;
  localparam int INIT   = 200;
  localparam int WIN    = 80;
  localparam int WIN_SS = 88;
  localparam int CLOSED = WIN / 4;
  localparam int WD_CYC = 20000;
  localparam int NVEC   = 9;

  // Table: edge position k of the trigger event after the last restart,
  // and pulse hold length in clock edges
  localparam int TAB_K [NVEC] = '{30, 50, 21, 20, 15, 80, 12, 40, 25};
  localparam int TAB_H [NVEC] = '{ 4,  4,  5,  4,  4,  6,  4,  4,  5};

  logic clk, rst_n, trig_in, mode_enter, active_mode, release_lvl, ss_sel;
  logic wd_fail;
  int   checks, bad, seen;

  wwd_window_watchdog #(
    .SYNC_STAGES (SYNC), .FILT_LEN (F), .INIT_CYC (INIT),
    .WIN_CYC (WIN), .WIN_SS_CYC (WIN_SS)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .trig_in (trig_in), .mode_enter (mode_enter),
    .active_mode (active_mode), .release_lvl (release_lvl), .ss_sel (ss_sel),
    .wd_fail (wd_fail)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wd_fail) seen++;
    end
  endtask

  // Lands a trigger event on the k-th edge after the current negedge
  task automatic place_trig(input int k, input int h);
    adv(k - LAT - 1);
    trig_in = 1'b1;
    adv(h);
    trig_in = 1'b0;
    adv(LAT + 1 - h);
  endtask

  task automatic pulse_mode_enter();
    mode_enter = 1'b1;
    adv(1);
    mode_enter = 1'b0;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    bit in_win;
    int exp;
    checks = 0; bad = 0; seen = 0;
    rst_n = 1'b0; trig_in = 1'b0; mode_enter = 1'b0;
    active_mode = 1'b0; release_lvl = 1'b0; ss_sel = 1'b0;
    adv(3);
    check(int'(wd_fail), 0, "R10 reset value");
    rst_n = 1'b1;
    pulse_mode_enter();

    // Table walk: closed/open/first-trigger decisions (R1 R3 R4 R5)
    in_win = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      exp  = (in_win && TAB_K[i] <= CLOSED) ? 1 : 0;
      seen = 0;
      place_trig(TAB_K[i], TAB_H[i]);
      if (exp == 1)      check(seen * 2 + int'(wd_fail), 3, "R4 early trigger");
      else if (in_win)   check(seen * 2 + int'(wd_fail), 0, "R5 open trigger");
      else               check(seen * 2 + int'(wd_fail), 0, "R3 first trigger");
      in_win = (exp == 0);
    end

    // R6: window runs out without a trigger
    seen = 0; adv(WIN - 1);
    check(seen, 0, "R6 no early timeout");
    adv(1);
    check(int'(wd_fail), 1, "R6 window timeout");

    // R2: initial timeout repeats
    seen = 0; adv(INIT - 1);
    check(seen, 0, "R2 no early timeout");
    adv(1);
    check(int'(wd_fail), 1, "R2 initial timeout");

    // R1: short pulse in the closed part is ignored; window still times out
    seen = 0; place_trig(30, F);
    check(seen, 0, "R3 enter window");
    place_trig(15, F - 1);
    check(seen, 0, "R1 short pulse ignored");
    adv(WIN - 15 - 1);
    check(seen, 0, "R1 window undisturbed");
    adv(1);
    check(int'(wd_fail), 1, "R1 timeout after short pulse");

    // R7: longer window when ss_sel is set
    ss_sel = 1'b1;
    seen = 0; place_trig(30, F);
    place_trig(22, F);
    check(seen * 2 + int'(wd_fail), 3, "R7 closed part scaled");
    seen = 0; place_trig(30, F);
    adv(WIN_SS - 1);
    check(seen, 0, "R7 no fail at short length");
    adv(1);
    check(int'(wd_fail), 1, "R7 long window timeout");
    ss_sel = 1'b0;

    // R8: mode entry re-arms the long timeout without a failure
    seen = 0; place_trig(30, F);
    adv(40);
    pulse_mode_enter();
    adv(INIT - 1);
    check(seen, 0, "R8 re-arm quiet");
    adv(1);
    check(int'(wd_fail), 1, "R8 timeout after re-arm");

    // R9: release rise ignored outside active mode
    seen = 0; place_trig(30, F);
    adv(20);
    release_lvl = 1'b1;
    adv(WIN - 21);
    check(seen, 0, "R9 inactive no fail early");
    adv(1);
    check(int'(wd_fail), 1, "R9 inactive release ignored");
    release_lvl = 1'b0;

    // R9: release rise in active mode re-arms, held level re-arms once
    seen = 0; place_trig(30, F);
    adv(20);
    active_mode = 1'b1;
    release_lvl = 1'b1;
    adv(INIT);
    check(seen, 0, "R9 active re-arm quiet");
    adv(1);
    check(int'(wd_fail), 1, "R9 active re-arm timeout");
    adv(1);
    check(int'(wd_fail), 0, "R10 single-cycle pulse");

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule